// File: doc/BRIEF.md
# I2C Target Register Interface

This block lets an I2C controller read and write a small register file that lives in the surrounding core. SCL and SDA arrive as sampled open-drain line values. The block releases SDA, or pulls it low through a single drive-enable output. Two strap inputs choose one of four 7-bit target addresses. A global enable switches the whole interface on or off.

The block keeps one 8-bit sub-address pointer. Writes and reads share it, and it keeps its value across transactions. In a write transfer, the first byte after the address loads the pointer. Each byte after that goes to the register the pointer selects, and the pointer then steps forward.

A read transfer carries no sub-address. It streams bytes starting at the pointer, and the pointer steps forward on every byte the controller acknowledges. To read from a chosen location, the controller first sends a write transfer that holds only the sub-address. It then sends a read, either after a STOP or after a repeated START.

Toward the core, the interface is a plain synchronous port. `reg_addr` always shows the pointer. A one-cycle `reg_wr_en` strobe carries `reg_wdata`. `reg_rdata` is a combinational read of `reg_addr` and is sampled while SCL is low.

Top module: `i2c_tgt_regif`

## Requirements
- R1: Reset state: `sda_oe` and `reg_wr_en` are 0, and `reg_addr` (the pointer) is 0x00.
- R2: The 7-bit own address is 0x5E, 0x5D, 0x5C or 0x5B for `strap` = 0, 1, 2 or 3. The first byte after a START is that address in bits 7..1, with bit 0 = 1 for a read. A matching address byte is acknowledged by holding SDA low during the ninth SCL pulse.
- R3: While `en` is 0, the block never drives SDA, issues no register write and leaves the pointer unchanged, whatever traffic is on the bus.
- R4: In a write transfer, every byte is acknowledged. Each byte after the first is written to the register at the pointer with a single-cycle `reg_wr_en` while `reg_addr` equals the pointer. After such a byte is acknowledged, the pointer increments.
- R5: A write transfer that carries only a sub-address byte loads the pointer. The next read, whether it follows a STOP or a repeated START, starts at that value.
- R6: A read sends bytes MSB first, starting at the pointer. The pointer increments after each byte the controller ACKs (SDA low in the ninth pulse). After a controller NACK, SDA is released, the pointer is left unchanged and the block waits for STOP or START.
- R7: STOP and START do not change the pointer. A read without a sub-address continues from where the last transfer left it.
- R8: Sub-addresses at or above `NUM_REGS` (default 16) read as 0x00 and produce no `reg_wr_en`. The pointer still advances over them.
- R9: The pointer is 8 bits wide and wraps from 0xFF to 0x00.
- R10: An address byte that does not match is not acknowledged. Every later byte is ignored until the next START or STOP: no ACK, no write and no pointer change.
- R11: A repeated START at any point restarts address matching.
- R12: SCL and SDA pass through a two-stage synchronizer. A START or STOP is an SDA edge while SCL is high. The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Interface enable |
| strap | input | STRAP_W (2) | Address select straps |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Current sub-address pointer |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr` |

## Verification
The embedded properties check, on every cycle, the following:
- The block falls idle and releases SDA while disabled.
- The SDA drive only rises while the synchronized SCL is low.
- Write strobes are single pulses aimed at implemented registers only.
- The pointer holds still while a read byte is shifted out.
- Nothing drives SDA after a mismatched address.

The bench scenarios cover the behaviour that only shows across whole transfers:
- the address sweep over all strap settings;
- pointer persistence across STOP and NACK;
- sub-address-only positioning;
- reserved reads returning zero;
- wrap-around at 0xFF;
- traffic that must leave the register file untouched.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_RD_LOAD,
      ST_SKIP
   } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= RST_VAL;
      else        stg_q[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[i] <= RST_VAL;
         else        stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

   a_r12_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({scl_rise, scl_fall, start_det, stop_det}) <= 1);

endmodule

// File: rtl/i2c_tgt_addr_map.sv
module i2c_tgt_addr_map #(
   parameter int         STRAP_W       = 2,
   parameter logic [6:0] BASE_ADDR     = 7'h5E,
   parameter bit         STRAP_DESCEND = 1'b1
) (
   input  logic [STRAP_W-1:0] strap,
   output logic [6:0]         own_addr
);

   localparam int SPAN = (1 << STRAP_W) - 1;

   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_w
      $error("i2c_tgt_addr_map: STRAP_W out of range");
   end
   if (STRAP_DESCEND && (int'(BASE_ADDR) < SPAN)) begin : g_bad_lo
      $error("i2c_tgt_addr_map: address range underflows");
   end
   if (!STRAP_DESCEND && (int'(BASE_ADDR) + SPAN > 127)) begin : g_bad_hi
      $error("i2c_tgt_addr_map: address range overflows");
   end

   logic [6:0] strap_ext;
   assign strap_ext = {{(7-STRAP_W){1'b0}}, strap};

   if (STRAP_DESCEND) begin : g_down
      assign own_addr = BASE_ADDR - strap_ext;
   end else begin : g_up
      assign own_addr = BASE_ADDR + strap_ext;
   end

endmodule

// File: rtl/i2c_tgt_regif.sv
module i2c_tgt_regif
   import i2c_tgt_pkg::*;
#(
   parameter int         NUM_REGS    = 16,
   parameter int         STRAP_W     = 2,
   parameter logic [6:0] BASE_ADDR   = 7'h5E,
   parameter int         SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [STRAP_W-1:0] strap,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   output logic               reg_wr_en,
   output logic [BYTE_W-1:0]  reg_addr,
   output logic [BYTE_W-1:0]  reg_wdata,
   input  logic [BYTE_W-1:0]  reg_rdata
);

   localparam logic [BYTE_W:0] NREG = (BYTE_W+1)'(NUM_REGS);

   if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_regs
      $error("i2c_tgt_regif: NUM_REGS must be 1..256");
   end

   logic [1:0] sync_q;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_det, stop_det;
   logic [6:0] own_addr;

   i2c_tgt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (sync_q)
   );
   assign scl_s = sync_q[1];
   assign sda_s = sync_q[0];

   i2c_tgt_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_tgt_addr_map #(.STRAP_W(STRAP_W), .BASE_ADDR(BASE_ADDR), .STRAP_DESCEND(1'b1)) u_amap (
      .strap    (strap),
      .own_addr (own_addr)
   );

   tgt_state_e        st_q;
   logic [2:0]        cnt_q;
   logic [BYTE_W-1:0] shr_q;
   logic [BYTE_W-1:0] ptr_q;
   logic [BYTE_W-1:0] wdata_q;
   logic              sda_drv_q, ack_pend_q, rw_q, first_q, data_q, wr_en_q;
   logic [BYTE_W-1:0] in_byte;
   logic [BYTE_W-1:0] rd_byte;
   logic              ptr_ok;

   assign in_byte = {shr_q[BYTE_W-2:0], sda_s};

   if (NUM_REGS >= 256) begin : g_full_map
      assign ptr_ok  = 1'b1;
      assign rd_byte = reg_rdata;
   end else begin : g_part_map
      assign ptr_ok  = ({1'b0, ptr_q} < NREG);
      assign rd_byte = ptr_ok ? reg_rdata : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         shr_q      <= '0;
         ptr_q      <= '0;
         wdata_q    <= '0;
         sda_drv_q  <= 1'b0;
         ack_pend_q <= 1'b0;
         rw_q       <= 1'b0;
         first_q    <= 1'b0;
         data_q     <= 1'b0;
         wr_en_q    <= 1'b0;
      end else begin
         wr_en_q <= 1'b0;
         if (!en) begin
            st_q       <= ST_IDLE;
            sda_drv_q  <= 1'b0;
            ack_pend_q <= 1'b0;
         end else if (start_det) begin
            st_q       <= ST_ADDR;
            cnt_q      <= '0;
            sda_drv_q  <= 1'b0;
            ack_pend_q <= 1'b0;
         end else if (stop_det) begin
            st_q       <= ST_IDLE;
            sda_drv_q  <= 1'b0;
            ack_pend_q <= 1'b0;
         end else begin
            unique case (st_q)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shr_q <= in_byte;
                     cnt_q <= cnt_q + 3'd1;
                     if (cnt_q == 3'd7) begin
                        if (in_byte[7:1] == own_addr) begin
                           rw_q       <= in_byte[0];
                           ack_pend_q <= 1'b1;
                           st_q       <= ST_ADDR_ACK;
                        end else begin
                           st_q <= ST_SKIP;
                        end
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (ack_pend_q) begin
                        sda_drv_q  <= 1'b1;
                        ack_pend_q <= 1'b0;
                     end else if (rw_q) begin
                        shr_q     <= rd_byte;
                        sda_drv_q <= ~rd_byte[BYTE_W-1];
                        cnt_q     <= '0;
                        st_q      <= ST_RD;
                     end else begin
                        sda_drv_q <= 1'b0;
                        cnt_q     <= '0;
                        first_q   <= 1'b1;
                        st_q      <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise) begin
                     shr_q <= in_byte;
                     cnt_q <= cnt_q + 3'd1;
                     if (cnt_q == 3'd7) begin
                        ack_pend_q <= 1'b1;
                        st_q       <= ST_WR_ACK;
                        if (first_q) begin
                           ptr_q   <= in_byte;
                           first_q <= 1'b0;
                           data_q  <= 1'b0;
                        end else begin
                           data_q  <= 1'b1;
                           wr_en_q <= ptr_ok;
                           wdata_q <= in_byte;
                        end
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     if (ack_pend_q) begin
                        sda_drv_q  <= 1'b1;
                        ack_pend_q <= 1'b0;
                     end else begin
                        sda_drv_q <= 1'b0;
                        if (data_q) ptr_q <= ptr_q + 1'b1;
                        data_q <= 1'b0;
                        cnt_q  <= '0;
                        st_q   <= ST_WR;
                     end
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     shr_q     <= {shr_q[BYTE_W-2:0], 1'b0};
                     sda_drv_q <= ~shr_q[BYTE_W-2];
                  end else if (scl_rise) begin
                     cnt_q <= cnt_q + 3'd1;
                     if (cnt_q == 3'd7) begin
                        ack_pend_q <= 1'b1;
                        st_q       <= ST_RD_ACK;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_fall && ack_pend_q) begin
                     sda_drv_q  <= 1'b0;
                     ack_pend_q <= 1'b0;
                  end else if (scl_rise && !ack_pend_q) begin
                     if (!sda_s) begin
                        ptr_q <= ptr_q + 1'b1;
                        st_q  <= ST_RD_LOAD;
                     end else begin
                        st_q <= ST_SKIP;
                     end
                  end
               end
               ST_RD_LOAD: begin
                  if (scl_fall) begin
                     shr_q     <= rd_byte;
                     sda_drv_q <= ~rd_byte[BYTE_W-1];
                     cnt_q     <= '0;
                     st_q      <= ST_RD;
                  end
               end
               default: begin
                  sda_drv_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign sda_oe    = sda_drv_q & en;
   assign reg_wr_en = wr_en_q;
   assign reg_addr  = ptr_q;
   assign reg_wdata = wdata_q;

   a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (st_q == ST_IDLE) && !sda_oe);

   a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n || !en)
      $rose(sda_drv_q) |-> !scl_s);

   a_r4_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   a_r8_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> ({1'b0, reg_addr} < NREG));

   a_r10_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SKIP) |-> !sda_oe);

   a_r6_ptr_hold_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RD) |-> $stable(ptr_q));

endmodule

// File: tb/i2c_tgt_regif_tb_top.sv
module i2c_tgt_regif_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b1;
   logic [1:0] strap = 2'd0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_oe, reg_wr_en;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic [7:0] mem [16];
   int         wr_cnt = 0;
   int         oe_off_viol = 0;
   int         oe_hi_chg = 0;
   logic       oe_prev = 1'b0;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;
   logic [7:0] rbuf [4];
   logic       ack_v [6];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = (reg_addr < 8'd16) ? mem[reg_addr[3:0]] : 8'hA5;

   i2c_tgt_regif dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .strap     (strap),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .reg_wr_en (reg_wr_en),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= 8'h30 + 8'(i);
         wr_cnt <= 0;
      end else if (reg_wr_en) begin
         wr_cnt <= wr_cnt + 1;
         if (reg_addr < 8'd16) mem[reg_addr[3:0]] <= reg_wdata;
      end
   end

   always @(posedge clk) begin
      if (!en && sda_oe) oe_off_viol <= oe_off_viol + 1;
      if (scl_m && (sda_oe != oe_prev)) oe_hi_chg <= oe_hi_chg + 1;
      oe_prev <= sda_oe;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq(QTR);
      scl_m = 1'b1; wq(QTR);
      sda_m = 1'b0; wq(QTR);
      scl_m = 1'b0; wq(QTR);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(QTR);
      scl_m = 1'b1; wq(QTR);
      sda_m = 1'b1; wq(QTR);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(QTR);
         scl_m = 1'b1; wq(2*QTR);
         scl_m = 1'b0; wq(QTR);
      end
      sda_m = 1'b1; wq(QTR);
      scl_m = 1'b1; wq(QTR);
      ack = sda_line; wq(QTR);
      scl_m = 1'b0; wq(QTR);
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(QTR);
         scl_m = 1'b1; wq(QTR);
         b[i] = sda_line; wq(QTR);
         scl_m = 1'b0; wq(QTR);
      end
      sda_m = nack; wq(QTR);
      scl_m = 1'b1; wq(2*QTR);
      scl_m = 1'b0; wq(QTR);
      sda_m = 1'b1;
   endtask

   function automatic logic [6:0] own(input logic [1:0] s);
      return 7'h5E - {5'd0, s};
   endfunction

   // Reads n bytes without sub-address; the last is NACKed.
   task automatic do_read(input logic [6:0] a, input int n, output logic aack);
      logic [7:0] b;
      i2c_start();
      send_byte({a, 1'b1}, aack);
      for (int i = 0; i < n; i++) begin
         recv_byte(i == n-1, b);
         rbuf[i] = b;
      end
      i2c_stop();
   endtask

   // Writes sub-address then n bytes starting at val; acks kept in ack_v.
   task automatic do_write(input logic [6:0] a, input logic [7:0] sub, input int n,
                           input logic [7:0] val, input bit stop_it);
      logic k;
      i2c_start();
      send_byte({a, 1'b0}, k); ack_v[0] = k;
      send_byte(sub, k);       ack_v[1] = k;
      for (int i = 0; i < n; i++) begin
         send_byte(val + 8'(i), k);
         ack_v[2+i] = k;
      end
      if (stop_it) i2c_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic a;
      int   w0;
      wq(10);
      // R1: reset state
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 reg_wr_en", reg_wr_en, 0);
      chk("R1 reg_addr", reg_addr, 0);
      rst_n = 1'b1;
      wq(10);
      chk("R1 reg_addr after release", reg_addr, 0);

      // R1/R7: read without sub-address starts at 0x00
      do_read(own(2'd0), 1, a);
      chk("R2 read addr ack", a, 0);
      chk("R1 first read at 0x00", rbuf[0], 8'h30);

      // R2: address sweep across all straps
      for (int s = 0; s < 4; s++) begin
         strap = 2'(s);
         wq(4);
         for (int ad = 8'h50; ad < 8'h60; ad++) begin
            i2c_start();
            send_byte({7'(ad), 1'b0}, a);
            i2c_stop();
            chk($sformatf("R2 strap=%0d addr=%0h ack", s, ad), a, (7'(ad) == own(2'(s))) ? 0 : 1);
         end
         do_read(own(2'(s)), 1, a);
         chk("R2 read-bit ack", a, 0);
         chk("R2 read-bit data", rbuf[0], 8'h30);
      end
      chk("R2 sweep no writes", wr_cnt, 0);

      strap = 2'd2;
      wq(4);
      // R4: write burst
      do_write(own(2'd2), 8'h03, 4, 8'hA0, 1'b1);
      for (int i = 0; i < 6; i++) chk("R4 write ack", ack_v[i], 0);
      for (int i = 0; i < 4; i++) chk("R4 reg content", mem[3+i], 8'hA0 + 8'(i));
      chk("R4 write count", wr_cnt, 4);
      chk("R4 pointer after burst", reg_addr, 8'h07);

      // R6/R7: read continues from pointer, NACK stops advance
      do_read(own(2'd2), 2, a);
      chk("R6 byte0", rbuf[0], 8'h37);
      chk("R6 byte1", rbuf[1], 8'h38);
      do_read(own(2'd2), 1, a);
      chk("R7 persist after nack", rbuf[0], 8'h38);

      // R5/R11: sub-address only, repeated START, read
      do_write(own(2'd2), 8'h04, 0, 8'h00, 1'b0);
      do_read(own(2'd2), 3, a);
      chk("R11 sr addr ack", a, 0);
      chk("R5 r11 byte0", rbuf[0], 8'hA1);
      chk("R5 r11 byte1", rbuf[1], 8'hA2);
      chk("R5 r11 byte2", rbuf[2], 8'hA3);

      // R5/R8: sub-address only with STOP, read into reserved
      do_write(own(2'd2), 8'h0E, 0, 8'h00, 1'b1);
      do_read(own(2'd2), 3, a);
      chk("R5 byte 0x0E", rbuf[0], 8'h3E);
      chk("R5 byte 0x0F", rbuf[1], 8'h3F);
      chk("R8 reserved 0x10 reads zero", rbuf[2], 8'h00);

      // R9: read wrap
      do_write(own(2'd2), 8'hFF, 0, 8'h00, 1'b1);
      do_read(own(2'd2), 2, a);
      chk("R8 r9 read 0xFF", rbuf[0], 8'h00);
      chk("R9 read wrap to 0x00", rbuf[1], 8'h30);

      // R8/R9: write wrap, reserved write suppressed
      w0 = wr_cnt;
      do_write(own(2'd2), 8'hFF, 2, 8'h11, 1'b1);
      chk("R8 reserved write ack", ack_v[2], 0);
      chk("R8 only one strobe", wr_cnt - w0, 1);
      chk("R9 write wrap lands at 0x00", mem[0], 8'h12);
      chk("R9 pointer after wrap", reg_addr, 8'h01);

      // R10: mismatched address ignored
      w0 = wr_cnt;
      do_write(7'h5E, 8'h09, 1, 8'h99, 1'b1);
      chk("R10 addr nack", ack_v[0], 1);
      chk("R10 sub nack", ack_v[1], 1);
      chk("R10 data nack", ack_v[2], 1);
      chk("R10 no write", wr_cnt - w0, 0);
      do_read(own(2'd2), 1, a);
      chk("R10 pointer kept", rbuf[0], 8'h31);

      // R3: disabled interface
      en = 1'b0;
      wq(4);
      w0 = wr_cnt;
      do_write(own(2'd2), 8'h05, 1, 8'h77, 1'b1);
      chk("R3 addr not acked", ack_v[0], 1);
      chk("R3 data not acked", ack_v[2], 1);
      chk("R3 no write", wr_cnt - w0, 0);
      chk("R3 never drove", oe_off_viol, 0);
      chk("R3 pointer unchanged", reg_addr, 8'h01);
      en = 1'b1;
      wq(4);
      do_read(own(2'd2), 1, a);
      chk("R3 read after enable", rbuf[0], 8'h31);
      chk("R3 reg 5 intact", mem[5], 8'hA2);

      // R11: repeated START right after sub-address to another location
      do_write(own(2'd2), 8'h02, 0, 8'h00, 1'b0);
      do_read(own(2'd2), 1, a);
      chk("R11 restart read", rbuf[0], 8'h32);

      // R12: drive only changes while SCL low
      chk("R12 no drive change with SCL high", oe_hi_chg, 0);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule